// File: doc/BRIEF.md
# Sensor Code to Temperature Converter

This block turns one raw reading from an on-die temperature sensor into a signed temperature in millidegrees Celsius. A calibration table built into the block pairs sensor codes with temperatures at a fixed temperature step. The block searches that table for the interval that holds the reading, then interpolates linearly inside the interval with truncating integer division. The result is finer than the table step.

A caller pulses a start strobe with the raw code and a direction select. The direction select says whether codes rise or fall as temperature rises. Some cycles later the block pulses done once. At that point it presents either a new temperature or an invalid flag for a reading that lies outside the table. The table holds one row of each direction, so a single build serves sensors of both kinds.

Top module: `tcode_temp_conv`

## Requirements
- R1: After synchronous reset, `done_o` and `invalid_o` are 0 and `temp_mc_o` is 0.
- R2: Only the low `DATA_W` bits of `raw_code_i` are used. Bits above them have no effect on the result.
- R3: Table entry i, for 0 ≤ i < `TBL_LEN`, has temperature `TEMP_BASE + i*TEMP_STEP`. With `falling_i` = 0 its code is `INC_BASE + i*INC_STEP + 3*(i mod 4)`. With `falling_i` = 1 its code is `DEC_TOP - i*DEC_STEP - 5*(i mod 3)`. A code equal to entry i > 0 of a valid interval yields exactly that entry's temperature. A `TBL_LEN` below 2 stops elaboration.
- R4: With rising codes (`falling_i` = 0), the interval is the smallest m in 1..`TBL_LEN-1` with code[m-1] ≤ code ≤ code[m]. The result is temp[m-1] + (temp[m]-temp[m-1])*(code-code[m-1]) / (code[m]-code[m-1]), with the quotient truncated.
- R5: With falling codes (`falling_i` = 1), the interval is the m with code[m] ≤ code < code[m-1]. The result is temp[m-1] + (temp[m]-temp[m-1])*(code[m-1]-code) / (code[m-1]-code[m]), with the quotient truncated.
- R6: With rising codes, a reading below code[0] or above code[`TBL_LEN-1`] is invalid. A reading equal to code[0] yields temp[0].
- R7: With falling codes, a reading at or below code[`TBL_LEN-1`], or at or above code[0], is invalid.
- R8: An invalid reading sets `invalid_o` to 1 and leaves `temp_mc_o` at its previous value. A valid reading clears `invalid_o`.
- R9: Each accepted start produces exactly one single-cycle `done_o` pulse. `temp_mc_o` and `invalid_o` change only in the cycle of that pulse.
- R10: A start pulse that arrives while a conversion is in progress is ignored. It does not alter the running conversion and does not produce a second done pulse.
- R11: A table of exactly two entries, which has a single interval, converts correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to convert `raw_code_i`; accepted only when idle |
| raw_code_i | input | RAW_W | Raw sensor reading; the low DATA_W bits are used |
| falling_i | input | 1 | Table direction: 0 = codes rise with temperature, 1 = codes fall |
| done_o | output | 1 | One-cycle pulse when a result is presented |
| temp_mc_o | output | TEMP_W | Signed temperature in millidegrees Celsius |
| invalid_o | output | 1 | Set when the last reading lay outside the table |

## Verification
The bench drives two builds side by side with the same stimulus. The default build has 34 entries, 12-bit codes, -40 °C to 125 °C and a six-level search. The other build has the minimum two entries, 10-bit codes and a falling row that ends at 900. The deep table exercises every search path and every exact table hit in both directions. The two-entry, 10-bit build reaches the single-interval case with no search step. The narrower mask also truncates most 12-bit readings, so one random stream drives the masking and both invalid edges of each table.

// File: rtl/tcode_pkg.sv
package tcode_pkg;

  // Fixed irregularity added to the linear code ramps so that interval
  // widths differ and interpolation is exercised with uneven denominators.
  localparam int INC_WOBBLE = 3;
  localparam int DEC_WOBBLE = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RANGE,
    ST_RCHK,
    ST_PROBE,
    ST_PCHK,
    ST_FETCH,
    ST_INTERP,
    ST_DIV
  } conv_state_t;

  function automatic int cal_code(input int idx, input bit falling,
                                  input int inc_base, input int inc_step,
                                  input int dec_top, input int dec_step);
    if (falling)
      return dec_top - idx * dec_step - (idx % 3) * DEC_WOBBLE;
    return inc_base + idx * inc_step + (idx % 4) * INC_WOBBLE;
  endfunction

  function automatic int cal_temp(input int idx, input int base, input int step);
    return base + idx * step;
  endfunction

endpackage

// File: rtl/tcode_cal_rom.sv
module tcode_cal_rom
  import tcode_pkg::*;
#(
  parameter int TBL_LEN   = 34,
  parameter int DATA_W    = 12,
  parameter int TEMP_W    = 20,
  parameter int IDX_W     = 6,
  parameter int TEMP_BASE = -40000,
  parameter int TEMP_STEP = 5000,
  parameter int INC_BASE  = 300,
  parameter int INC_STEP  = 24,
  parameter int DEC_TOP   = 3800,
  parameter int DEC_STEP  = 70
) (
  input  logic                     clk,
  input  logic [IDX_W:0]           addr_a,
  input  logic [IDX_W:0]           addr_b,
  output logic [DATA_W-1:0]        code_a,
  output logic signed [TEMP_W-1:0] temp_a,
  output logic [DATA_W-1:0]        code_b,
  output logic signed [TEMP_W-1:0] temp_b
);

  localparam int SLOTS = 2 ** IDX_W;
  localparam int DEPTH = 2 * SLOTS;
  localparam int ENT_W = DATA_W + TEMP_W;

  // Upper half holds the falling-code row, lower half the rising-code row.
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] q_a, q_b;

  initial begin
    for (int i = 0; i < SLOTS; i++) begin
      if (i < TBL_LEN) begin
        mem[i] = {DATA_W'(cal_code(i, 1'b0, INC_BASE, INC_STEP, DEC_TOP, DEC_STEP)),
                  TEMP_W'(cal_temp(i, TEMP_BASE, TEMP_STEP))};
        mem[i + SLOTS] = {DATA_W'(cal_code(i, 1'b1, INC_BASE, INC_STEP, DEC_TOP, DEC_STEP)),
                          TEMP_W'(cal_temp(i, TEMP_BASE, TEMP_STEP))};
      end else begin
        mem[i]         = '0;
        mem[i + SLOTS] = '0;
      end
    end
  end

  // Two synchronous read ports, one cycle of latency.
  always_ff @(posedge clk) begin
    q_a <= mem[addr_a];
    q_b <= mem[addr_b];
  end

  assign code_a = q_a[ENT_W-1:TEMP_W];
  assign temp_a = q_a[TEMP_W-1:0];
  assign code_b = q_b[ENT_W-1:TEMP_W];
  assign temp_b = q_b[TEMP_W-1:0];

endmodule

// File: rtl/tcode_divider.sv
module tcode_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);

  localparam int CNT_W = $clog2(NUM_W);

  logic [NUM_W-1:0] work_r;
  logic [DEN_W-1:0] rem_r;
  logic [DEN_W-1:0] den_r;
  logic [CNT_W-1:0] cnt_r;
  logic             run_r;
  logic             done_r;

  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             fits;
  logic             unused_trial_msb;

  // One restoring step: bring in the next dividend bit, try the subtract.
  always_comb begin
    shifted = {rem_r, work_r[NUM_W-1]};
    trial   = {1'b0, shifted} - {2'b00, den_r};
    fits    = ~trial[DEN_W+1];
  end
  assign unused_trial_msb = trial[DEN_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      work_r <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      cnt_r  <= '0;
      run_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (go_i) begin
        work_r <= num_i;
        rem_r  <= '0;
        den_r  <= den_i;
        cnt_r  <= CNT_W'(NUM_W - 1);
        run_r  <= 1'b1;
      end else if (run_r) begin
        rem_r  <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
        work_r <= {work_r[NUM_W-2:0], fits};
        if (cnt_r == '0) begin
          run_r  <= 1'b0;
          done_r <= 1'b1;
        end else begin
          cnt_r <= cnt_r - CNT_W'(1);
        end
      end
    end
  end

  assign done_o = done_r;
  assign quo_o  = work_r;

  // A strictly monotonic table never hands over a zero interval width.
  assert_den_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    go_i |-> (den_i != '0));

  // A result is only reported for a division that was started.
  assert_done_after_run_R9: assert property (@(posedge clk) disable iff (rst)
    done_r |-> !run_r);

endmodule

// File: rtl/tcode_search_ctrl.sv
module tcode_search_ctrl
  import tcode_pkg::*;
#(
  parameter int TBL_LEN = 34,
  parameter int DATA_W  = 12,
  parameter int RAW_W   = 16,
  parameter int TEMP_W  = 20,
  parameter int IDX_W   = 6,
  parameter int NUM_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [RAW_W-1:0]         raw_i,
  input  logic                     falling_i,
  output logic [IDX_W:0]           addr_a_o,
  output logic [IDX_W:0]           addr_b_o,
  input  logic [DATA_W-1:0]        code_a_i,
  input  logic signed [TEMP_W-1:0] temp_a_i,
  input  logic [DATA_W-1:0]        code_b_i,
  input  logic signed [TEMP_W-1:0] temp_b_i,
  output logic                     div_go_o,
  output logic [NUM_W-1:0]         div_num_o,
  output logic [DATA_W-1:0]        div_den_o,
  input  logic                     div_done_i,
  input  logic [NUM_W-1:0]         div_quo_i,
  output logic                     done_o,
  output logic signed [TEMP_W-1:0] temp_o,
  output logic                     invalid_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_LEN - 1);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

  conv_state_t              state;
  logic [DATA_W-1:0]        code_r;
  logic                     fall_r;
  logic [IDX_W-1:0]         lo_r, hi_r, mid_r;
  logic signed [TEMP_W-1:0] base_r;
  logic [TEMP_W-1:0]        span_r;
  logic                     go_r;
  logic [NUM_W-1:0]         num_r;
  logic [DATA_W-1:0]        den_r;
  logic                     done_r;
  logic signed [TEMP_W-1:0] temp_r;
  logic                     inv_r;

  generate
    if (RAW_W > DATA_W) begin : g_raw_hi
      logic unused_raw_hi;
      assign unused_raw_hi = ^raw_i[RAW_W-1:DATA_W];
    end
  endgenerate

  // Search step helpers.
  logic [IDX_W:0]   mid_sum;
  logic [IDX_W-1:0] mid_w;
  logic [IDX_W-1:0] lo_dec;
  logic             probe_hit;
  logic [IDX_W-1:0] nlo, nhi;
  logic             range_bad;

  assign mid_sum = {1'b0, lo_r} + {1'b0, hi_r};
  assign mid_w   = IDX_W'(mid_sum >> 1);
  assign lo_dec  = lo_r - ONE_IDX;

  // Lower-bound search: the first index whose code has reached the reading.
  assign probe_hit = fall_r ? (code_r >= code_a_i) : (code_r <= code_a_i);
  assign nlo       = probe_hit ? lo_r  : mid_r + ONE_IDX;
  assign nhi       = probe_hit ? mid_r : hi_r;

  // Port a holds entry 0 and port b the last entry while the range is checked.
  assign range_bad = fall_r ? ((code_r <= code_b_i) || (code_r >= code_a_i))
                            : ((code_r <  code_a_i) || (code_r >  code_b_i));

  // Interpolation operands; port a holds entry m-1 and port b entry m.
  logic signed [TEMP_W-1:0] span_s;
  logic [DATA_W-1:0]        adiff, dden;

  assign span_s = temp_b_i - temp_a_i;
  assign adiff  = fall_r ? (code_a_i - code_r)   : (code_r - code_a_i);
  assign dden   = fall_r ? (code_a_i - code_b_i) : (code_b_i - code_a_i);

  always_comb begin
    addr_a_o = {fall_r, {IDX_W{1'b0}}};
    addr_b_o = {fall_r, LAST_IDX};
    unique case (state)
      ST_PROBE: addr_a_o = {fall_r, mid_w};
      ST_FETCH: begin
        addr_a_o = {fall_r, lo_dec};
        addr_b_o = {fall_r, lo_r};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      code_r <= '0;
      fall_r <= 1'b0;
      lo_r   <= '0;
      hi_r   <= '0;
      mid_r  <= '0;
      base_r <= '0;
      span_r <= '0;
      go_r   <= 1'b0;
      num_r  <= '0;
      den_r  <= '0;
      done_r <= 1'b0;
      temp_r <= '0;
      inv_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      go_r   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            code_r <= raw_i[DATA_W-1:0];
            fall_r <= falling_i;
            state  <= ST_RANGE;
          end
        end
        ST_RANGE: state <= ST_RCHK;
        ST_RCHK: begin
          if (range_bad) begin
            inv_r  <= 1'b1;
            done_r <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            lo_r  <= ONE_IDX;
            hi_r  <= LAST_IDX;
            state <= (LAST_IDX == ONE_IDX) ? ST_FETCH : ST_PROBE;
          end
        end
        ST_PROBE: begin
          mid_r <= mid_w;
          state <= ST_PCHK;
        end
        ST_PCHK: begin
          lo_r  <= nlo;
          hi_r  <= nhi;
          state <= (nlo == nhi) ? ST_FETCH : ST_PROBE;
        end
        ST_FETCH: state <= ST_INTERP;
        ST_INTERP: begin
          base_r <= temp_a_i;
          span_r <= $unsigned(span_s);
          num_r  <= NUM_W'($unsigned(span_s)) * NUM_W'(adiff);
          den_r  <= dden;
          go_r   <= 1'b1;
          state  <= ST_DIV;
        end
        ST_DIV: begin
          if (div_done_i) begin
            temp_r <= base_r + $signed(div_quo_i[TEMP_W-1:0]);
            inv_r  <= 1'b0;
            done_r <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign div_go_o  = go_r;
  assign div_num_o = num_r;
  assign div_den_o = den_r;
  assign done_o    = done_r;
  assign temp_o    = temp_r;
  assign invalid_o = inv_r;

  // Rising-code interval returned by the search must hold the reading.
  assert_bracket_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INTERP && !fall_r) |-> (code_a_i <= code_r && code_r <= code_b_i));

  // Falling-code interval returned by the search must hold the reading.
  assert_bracket_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INTERP && fall_r) |-> (code_b_i <= code_r && code_r < code_a_i));

  // The interpolated step never exceeds the interval's temperature span.
  assert_quot_in_span_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIV && div_done_i) |-> (div_quo_i <= NUM_W'(span_r)));

  assert_hold_on_invalid_R8: assert property (@(posedge clk) disable iff (rst)
    (done_r && inv_r) |-> $stable(temp_r));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_r |=> !done_r);

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (start_i && state != ST_IDLE) |=> $stable(code_r));

endmodule

// File: rtl/tcode_temp_conv.sv
module tcode_temp_conv
  import tcode_pkg::*;
#(
  parameter int TBL_LEN   = 34,
  parameter int DATA_W    = 12,
  parameter int RAW_W     = 16,
  parameter int TEMP_W    = 20,
  parameter int TEMP_BASE = -40000,
  parameter int TEMP_STEP = 5000,
  parameter int INC_BASE  = 300,
  parameter int INC_STEP  = 24,
  parameter int DEC_TOP   = 3800,
  parameter int DEC_STEP  = 70
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [RAW_W-1:0]         raw_code_i,
  input  logic                     falling_i,
  output logic                     done_o,
  output logic signed [TEMP_W-1:0] temp_mc_o,
  output logic                     invalid_o
);

  localparam int IDX_W = $clog2(TBL_LEN);
  localparam int NUM_W = TEMP_W + DATA_W;

  initial begin
    assert_tbl_len_R3: assert (TBL_LEN >= 2)
      else $error("calibration table needs at least two entries");
  end

  logic [IDX_W:0]           addr_a, addr_b;
  logic [DATA_W-1:0]        code_a, code_b;
  logic signed [TEMP_W-1:0] temp_a, temp_b;
  logic                     div_go, div_done;
  logic [NUM_W-1:0]         div_num, div_quo;
  logic [DATA_W-1:0]        div_den;

  tcode_cal_rom #(
    .TBL_LEN(TBL_LEN), .DATA_W(DATA_W), .TEMP_W(TEMP_W), .IDX_W(IDX_W),
    .TEMP_BASE(TEMP_BASE), .TEMP_STEP(TEMP_STEP),
    .INC_BASE(INC_BASE), .INC_STEP(INC_STEP),
    .DEC_TOP(DEC_TOP), .DEC_STEP(DEC_STEP)
  ) rom_i (
    .clk(clk),
    .addr_a(addr_a), .addr_b(addr_b),
    .code_a(code_a), .temp_a(temp_a),
    .code_b(code_b), .temp_b(temp_b)
  );

  tcode_search_ctrl #(
    .TBL_LEN(TBL_LEN), .DATA_W(DATA_W), .RAW_W(RAW_W),
    .TEMP_W(TEMP_W), .IDX_W(IDX_W), .NUM_W(NUM_W)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .start_i(start_i), .raw_i(raw_code_i), .falling_i(falling_i),
    .addr_a_o(addr_a), .addr_b_o(addr_b),
    .code_a_i(code_a), .temp_a_i(temp_a),
    .code_b_i(code_b), .temp_b_i(temp_b),
    .div_go_o(div_go), .div_num_o(div_num), .div_den_o(div_den),
    .div_done_i(div_done), .div_quo_i(div_quo),
    .done_o(done_o), .temp_o(temp_mc_o), .invalid_o(invalid_o)
  );

  tcode_divider #(
    .NUM_W(NUM_W), .DEN_W(DATA_W)
  ) div_i (
    .clk(clk), .rst(rst),
    .go_i(div_go), .num_i(div_num), .den_i(div_den),
    .done_o(div_done), .quo_o(div_quo)
  );

endmodule

// File: tb/tcode_temp_conv_tb_top.sv
`timescale 1ns/1ps
module tcode_temp_conv_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_in = 1'b0;
  logic [15:0] raw_in = '0;
  logic        mode_in = 1'b0;

  logic               done_a, inv_a, done_b, inv_b;
  logic signed [19:0] temp_a, temp_b;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int n_done [2];
  int cap_temp [2];
  bit cap_inv [2];
  int exp_prev [2];

  always #10 clk = ~clk;

  tcode_temp_conv dut_i (
    .clk(clk), .rst(rst), .start_i(start_in), .raw_code_i(raw_in),
    .falling_i(mode_in), .done_o(done_a), .temp_mc_o(temp_a), .invalid_o(inv_a)
  );

  tcode_temp_conv #(
    .TBL_LEN(2), .DATA_W(10), .DEC_TOP(900), .DEC_STEP(70)
  ) dut_min_i (
    .clk(clk), .rst(rst), .start_i(start_in), .raw_code_i(raw_in),
    .falling_i(mode_in), .done_o(done_b), .temp_mc_o(temp_b), .invalid_o(inv_b)
  );

  initial begin
    n_done[0] = 0; n_done[1] = 0;
    exp_prev[0] = 0; exp_prev[1] = 0;
  end

  always @(negedge clk) begin
    if (done_a) begin
      n_done[0]++;
      cap_temp[0] = int'(temp_a);
      cap_inv[0]  = inv_a;
    end
    if (done_b) begin
      n_done[1]++;
      cap_temp[1] = int'(temp_b);
      cap_inv[1]  = inv_b;
    end
  end

  // ---- reference model built from the requirements ----
  function automatic int tb_len(input int cfg);
    return (cfg == 0) ? 34 : 2;
  endfunction

  function automatic int tb_code(input int cfg, input int i, input bit fall);
    int top, dstep;
    top   = (cfg == 0) ? 3800 : 900;
    dstep = 70;
    if (fall) return top - i * dstep - 5 * (i % 3);
    return 300 + i * 24 + 3 * (i % 4);
  endfunction

  function automatic int tb_temp(input int i);
    return -40000 + i * 5000;
  endfunction

  function automatic void model(input int cfg, input int raw, input bit fall,
                                output bit inv, output int t);
    int c, len, c0, cl, m, ca, cb, num, den;
    c   = raw & ((cfg == 0) ? 32'hFFF : 32'h3FF);
    len = tb_len(cfg);
    c0  = tb_code(cfg, 0, fall);
    cl  = tb_code(cfg, len - 1, fall);
    inv = fall ? (c <= cl || c >= c0) : (c < c0 || c > cl);
    t = 0;
    if (!inv) begin
      m = len - 1;
      for (int i = len - 1; i >= 1; i--)
        if (fall ? (c >= tb_code(cfg, i, fall)) : (c <= tb_code(cfg, i, fall))) m = i;
      ca  = tb_code(cfg, m - 1, fall);
      cb  = tb_code(cfg, m, fall);
      num = (tb_temp(m) - tb_temp(m - 1)) * (fall ? (ca - c) : (c - ca));
      den = fall ? (ca - cb) : (cb - ca);
      t   = tb_temp(m - 1) + num / den;
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic convert(input int raw, input bit fall, input string req, input int busy_raw);
    int base [2];
    bit ei;
    int et;
    @(posedge clk);
    base[0] = n_done[0];
    base[1] = n_done[1];
    @(negedge clk);
    raw_in = 16'(raw); mode_in = fall; start_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0;
    if (busy_raw >= 0) begin
      repeat (3) @(negedge clk);
      raw_in = 16'(busy_raw); mode_in = ~fall; start_in = 1'b1;
      @(negedge clk);
      start_in = 1'b0;
    end
    for (int k = 0; k < 400; k++) begin
      @(posedge clk);
      if (n_done[0] != base[0] && n_done[1] != base[1]) break;
    end
    repeat ((busy_raw >= 0) ? 80 : 4) @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      model(d, raw, fall, ei, et);
      if (ei) et = exp_prev[d];
      check(n_done[d] - base[d] == 1, (busy_raw >= 0) ? "R10" : "R9",
            $sformatf("done pulses inst%0d", d), n_done[d] - base[d], 1);
      check(cap_inv[d] == ei, req, $sformatf("invalid inst%0d code=%0d", d, raw),
            int'(cap_inv[d]), int'(ei));
      check(cap_temp[d] == et, req, $sformatf("temp inst%0d code=%0d mode=%0d", d, raw, fall),
            cap_temp[d], et);
      exp_prev[d] = et;
    end
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    int r, c, lo, hi;
    bit f;
    seed_dummy = $urandom(32'h1BADCAFE);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check(done_a == 1'b0 && done_b == 1'b0, "R1", "done after reset", int'(done_a | done_b), 0);
    check(inv_a == 1'b0 && inv_b == 1'b0, "R1", "invalid after reset", int'(inv_a | inv_b), 0);
    check(temp_a == 0 && temp_b == 0, "R1", "temp after reset", int'(temp_a), 0);

    // R3: exact hits on every table entry, both directions
    for (int i = 0; i < 34; i++) begin
      convert(tb_code(0, i, 1'b0), 1'b0, "R3", -1);
      convert(tb_code(0, i, 1'b1), 1'b1, "R3", -1);
    end

    // R6: rising-code range edges
    convert(tb_code(0, 0, 1'b0) - 1, 1'b0, "R6", -1);
    convert(tb_code(0, 0, 1'b0), 1'b0, "R6", -1);
    convert(tb_code(0, 33, 1'b0), 1'b0, "R6", -1);
    convert(tb_code(0, 33, 1'b0) + 1, 1'b0, "R6", -1);

    // R7: falling-code range edges
    convert(tb_code(0, 33, 1'b1), 1'b1, "R7", -1);
    convert(tb_code(0, 33, 1'b1) + 1, 1'b1, "R7", -1);
    convert(tb_code(0, 0, 1'b1) - 1, 1'b1, "R7", -1);
    convert(tb_code(0, 0, 1'b1), 1'b1, "R7", -1);

    // R8: a valid result followed by an invalid reading keeps the temperature
    convert(tb_code(0, 12, 1'b0) + 7, 1'b0, "R8", -1);
    convert(5, 1'b0, "R8", -1);
    convert(4000, 1'b1, "R8", -1);

    // R2: junk above the data width has no effect
    convert(32'hF000 | (tb_code(0, 7, 1'b0) + 1), 1'b0, "R2", -1);
    convert(32'hA000 | (tb_code(0, 10, 1'b1) - 2), 1'b1, "R2", -1);

    // R11: single-interval table, both directions
    for (int i = 0; i < 8; i++) begin
      convert(300 + int'($urandom % 28), 1'b0, "R11", -1);
      convert(825 + int'($urandom % 75), 1'b1, "R11", -1);
    end

    // R10: second start during a conversion is ignored
    convert(313, 1'b0, "R10", 320);

    // R4 / R5: random readings, in range and anywhere
    for (int n = 0; n < 150; n++) begin
      r = int'($urandom);
      f = r[0];
      if (r[1]) begin
        lo = f ? tb_code(0, 33, 1'b1) : tb_code(0, 0, 1'b0);
        hi = f ? tb_code(0, 0, 1'b1)  : tb_code(0, 33, 1'b0);
        c  = lo + int'($urandom % (hi - lo + 1));
      end else begin
        c = int'($urandom & 32'hFFFF);
      end
      convert(c, f, f ? "R5" : "R4", -1);
    end

    summary();
    $finish;
  end

endmodule